// File: doc/BRIEF.md
# Multiformat Audio Serial Transmitter

This block turns parallel audio sample words into a serial bit stream with a matching frame-sync line. It is meant to sit behind a sample source that offers one word per channel slot through a valid/ready handshake. A single-cycle bit-clock enable, generated elsewhere, sets the pace: every enabled cycle emits one serial bit.

The framing can be two-channel I2S, two-channel left-justified, or a multi-slot TDM frame with or without a one-bit data delay. The sample length is chosen from a 3-bit code, and two-channel framing can use a narrow 24-bit slot for the mid-length samples. A mono option copies each even slot's sample into the odd slot after it. When the source has no word ready at a slot start, the slot is filled with either zero or the previous slot's sample, and a one-cycle underrun pulse is raised.

All mode inputs are expected to stay constant while the block runs. They are changed only while reset is held.

Top module: `aud_serial_tx`

## Requirements
- R1: While `rst_n` is low, and before the first enabled cycle after it, `sdata`, `fsync` and `underrun` are 0 and `s_ready` is 0. The frame restarts at slot 0, bit 0.
- R2: Only cycles with `bit_en` high advance the frame. On any other cycle `sdata` and `fsync` keep their values and `underrun` is 0.
- R3: `len_sel` gives the sample length in bits. Codes 0..7 map to 32, 24, 20, 18, 16, 16, 8 and 8. The packed codes 5 and 7 serialize exactly like 4 and 6. The sample sits in the low bits of `s_data` and is sent MSB first, and all slot bits after its LSB are 0.
- R4: The slot is 24 bits wide when `fmt_sel` is 0 or 1, `narrow_slot` is 1 and `len_sel` is 1, 2 or 3. In every other case the slot is 32 bits wide, and all TDM slots are 32 bits.
- R5: `fmt_sel` 0 (I2S) and 2 (TDM) put each serial bit out one bit period after its slot position. `fmt_sel` 1 (left-justified) and 3 (TDM left-justified) put it out in that position. The first delayed bit after reset is 0.
- R6: A frame has 2 slots when `fmt_sel` is 0 or 1, and `tdm_ch_m1`+1 slots when `fmt_sel` is 2 or 3.
- R7: With `fmt_sel` 0, `fsync` is 0 during slot 0 (left) and 1 during slot 1 (right). With `fmt_sel` 1 it is 1 during slot 0 and 0 during slot 1.
- R8: In TDM framing `fsync` is an active-high pulse that starts at bit 0 of slot 0. With `sync_sel` 0 or 3 it lasts one slot, with 1 it lasts half the frame's bits, and with 2 it lasts one bit.
- R9: `s_ready` is high only in an enabled cycle at bit 0 of a slot that needs a new sample. A word is taken when `s_valid` and `s_ready` are both high, and `s_data` bits above the sample length are ignored.
- R10: With `mono_en` set, every odd-numbered slot repeats the sample of the slot before it and requests no word from the source.
- R11: If a slot needs a sample and `s_valid` is low, `underrun` is high for exactly the one cycle after that enabled edge.
- R12: On underrun, the slot carries zero when `fill_prev` is 0 and repeats the previous slot's sample when `fill_prev` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle bit-clock enable |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 TDM, 3 TDM left-justified |
| len_sel | input | 3 | Sample length code |
| narrow_slot | input | 1 | Use a 24-bit slot for 18/20/24-bit samples in two-channel framing |
| tdm_ch_m1 | input | 3 | TDM slot count minus one |
| sync_sel | input | 2 | TDM frame-sync width: 0 slot, 1 half frame, 2 bit, 3 slot |
| mono_en | input | 1 | Duplicate even-slot samples into odd slots |
| fill_prev | input | 1 | Underrun fill: 0 zero, 1 previous sample |
| s_valid | input | 1 | Sample word offered |
| s_data | input | 32 | Sample word, right-aligned |
| s_ready | output | 1 | Sample word accepted this cycle when valid |
| sdata | output | 1 | Serial data |
| fsync | output | 1 | Frame sync |
| underrun | output | 1 | One-cycle pulse on a missing sample |

## Verification
The bench runs ten mode setups: I2S and left-justified at 16, 18, 20, 24 and 32 bits with both slot widths, TDM with 1, 3, 4, 5 and 8 slots under each frame-sync width, and the mono and packed length codes. Running the bit enable at every cycle and at one cycle in two or three separates the per-bit advance from the hold behaviour. Random upper bits in the offered words show whether the length mask is applied. Starvation windows, run under both fill policies, tell a zero fill from a repeated sample, and under mono they show that the copied slot follows what was actually sent rather than what was last received.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    localparam int WORD_W   = 32;
    localparam int NARROW_W = 24;
    localparam int LEN_W    = $clog2(WORD_W) + 1;
    localparam int POS_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {
        FMT_I2S    = 2'd0,
        FMT_LJ     = 2'd1,
        FMT_TDM    = 2'd2,
        FMT_TDM_LJ = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        SYNC_SLOT = 2'd0,
        SYNC_HALF = 2'd1,
        SYNC_BIT  = 2'd2,
        SYNC_ALT  = 2'd3
    } sync_w_e;

    // Sample length in bits for a length code
    function automatic logic [LEN_W-1:0] sample_bits(input logic [2:0] code);
        case (code)
            3'd0:       return LEN_W'(32);
            3'd1:       return LEN_W'(24);
            3'd2:       return LEN_W'(20);
            3'd3:       return LEN_W'(18);
            3'd4, 3'd5: return LEN_W'(16);
            default:    return LEN_W'(8);
        endcase
    endfunction

    // Slot width in bits; the narrow slot applies to two-channel framing only
    function automatic logic [LEN_W-1:0] slot_bits(input logic [1:0] fmt,
                                                   input logic [2:0] code,
                                                   input logic narrow);
        if (!fmt[1] && narrow && (code inside {3'd1, 3'd2, 3'd3}))
            return LEN_W'(NARROW_W);
        return LEN_W'(WORD_W);
    endfunction
endpackage

// File: rtl/aud_tx_timing.sv
module aud_tx_timing
    import aud_tx_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int CH_W   = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        fmt_i,
    input  logic [2:0]        len_i,
    input  logic              narrow_i,
    input  logic [CH_W-1:0]   nch_m1_i,
    input  logic [1:0]        sync_i,
    output logic [POS_W-1:0]  pos_o,
    output logic [CH_W-1:0]   slot_o,
    output logic              fsync_o
);
    localparam int IDX_W = CH_W + POS_W + 1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CH_W-1:0]  slot;
        logic             fsync;
    } tim_t;

    tim_t r_q, r_d;
    frame_fmt_e       fmt;
    sync_w_e          sync_w;
    logic [LEN_W-1:0] slot_len_m1_full;
    logic [POS_W-1:0] slot_len_m1;
    logic [CH_W-1:0]  last_slot;
    logic [CH_W:0]    nch;
    logic [IDX_W-1:0] frame_idx, half_len;
    logic             fs;

    assign fmt    = frame_fmt_e'(fmt_i);
    assign sync_w = sync_w_e'(sync_i);

    always_comb begin
        slot_len_m1_full = slot_bits(fmt_i, len_i, narrow_i) - LEN_W'(1);
        slot_len_m1      = slot_len_m1_full[POS_W-1:0];
        last_slot        = fmt_i[1] ? nch_m1_i : CH_W'(1);
        nch              = {1'b0, nch_m1_i} + {{CH_W{1'b0}}, 1'b1};
        frame_idx        = {1'b0, r_q.slot, r_q.pos};
        half_len         = {1'b0, nch, {(POS_W-1){1'b0}}};

        case (fmt)
            FMT_I2S: fs = (r_q.slot == CH_W'(1));
            FMT_LJ:  fs = (r_q.slot == '0);
            default: begin
                case (sync_w)
                    SYNC_HALF: fs = (frame_idx < half_len);
                    SYNC_BIT:  fs = (r_q.slot == '0) && (r_q.pos == '0);
                    default:   fs = (r_q.slot == '0);
                endcase
            end
        endcase

        r_d = r_q;
        if (bit_en) begin
            r_d.fsync = fs;
            if (r_q.pos >= slot_len_m1) begin
                r_d.pos  = '0;
                r_d.slot = (r_q.slot >= last_slot) ? '0 : r_q.slot + CH_W'(1);
            end else begin
                r_d.pos = r_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pos_o   = r_q.pos;
    assign slot_o  = r_q.slot;
    assign fsync_o = r_q.fsync;

    // R4
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pos <= slot_len_m1);
    // R6
    slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.slot <= last_slot);
    // R2
    fsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(fsync_o));
endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
    import aud_tx_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [CH_W-1:0]   slot_i,
    input  logic [1:0]        fmt_i,
    input  logic [2:0]        len_i,
    input  logic              mono_i,
    input  logic              fill_prev_i,
    input  logic              s_valid_i,
    input  logic [WORD_W-1:0] s_data_i,
    output logic              s_ready_o,
    output logic              sdata_o,
    output logic              underrun_o
);
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] sent;
        logic              prev_raw;
        logic              sdata;
        logic              unf;
    } ser_t;

    ser_t r_q, r_d;
    logic [LEN_W-1:0]  len, pad;
    logic [WORD_W-1:0] mask, word, aligned;
    logic              slot_start, need, delayed, raw;

    always_comb begin
        len        = sample_bits(len_i);
        pad        = LEN_W'(WORD_W) - len;
        mask       = (len == LEN_W'(WORD_W)) ? '1 : ((WORD_W'(1) << len) - WORD_W'(1));
        slot_start = (pos_i == '0);
        need       = slot_start && !(mono_i && slot_i[0]);
        delayed    = !fmt_i[0];
        s_ready_o  = bit_en && need;

        word = r_q.sent;
        if (need) begin
            if (s_valid_i)        word = s_data_i & mask;
            else if (!fill_prev_i) word = '0;
        end
        aligned = word << pad;

        r_d     = r_q;
        r_d.unf = 1'b0;
        raw     = r_q.shreg[WORD_W-1];
        if (bit_en) begin
            if (slot_start) begin
                raw       = aligned[WORD_W-1];
                r_d.shreg = aligned << 1;
                r_d.sent  = word;
                r_d.unf   = need && !s_valid_i;
            end else begin
                r_d.shreg = r_q.shreg << 1;
            end
            r_d.sdata    = delayed ? r_q.prev_raw : raw;
            r_d.prev_raw = raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sdata_o    = r_q.sdata;
    assign underrun_o = r_q.unf;

    // R11
    unf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);
    // R10
    mono_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_i && slot_i[0]) |-> !s_ready_o);
    // R9
    ready_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (pos_i == '0));
    // R2
    sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sdata_o) && !underrun_o));
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int MAX_CH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_en,
    input  logic [1:0]                 fmt_sel,
    input  logic [2:0]                 len_sel,
    input  logic                       narrow_slot,
    input  logic [$clog2(MAX_CH)-1:0]  tdm_ch_m1,
    input  logic [1:0]                 sync_sel,
    input  logic                       mono_en,
    input  logic                       fill_prev,
    input  logic                       s_valid,
    input  logic [WORD_W-1:0]          s_data,
    output logic                       s_ready,
    output logic                       sdata,
    output logic                       fsync,
    output logic                       underrun
);
    localparam int CH_W = $clog2(MAX_CH);

    logic [POS_W-1:0] pos;
    logic [CH_W-1:0]  slot;

    aud_tx_timing #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .fmt_i    (fmt_sel),
        .len_i    (len_sel),
        .narrow_i (narrow_slot),
        .nch_m1_i (tdm_ch_m1),
        .sync_i   (sync_sel),
        .pos_o    (pos),
        .slot_o   (slot),
        .fsync_o  (fsync)
    );

    aud_tx_serializer #(.CH_W(CH_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .pos_i       (pos),
        .slot_i      (slot),
        .fmt_i       (fmt_sel),
        .len_i       (len_sel),
        .mono_i      (mono_en),
        .fill_prev_i (fill_prev),
        .s_valid_i   (s_valid),
        .s_data_i    (s_data),
        .s_ready_o   (s_ready),
        .sdata_o     (sdata),
        .underrun_o  (underrun)
    );
endmodule

// File: tb/aud_serial_tx_bench.sv
module aud_serial_tx_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [2:0]  len_sel = 3'd0;
    logic        narrow_slot = 1'b0;
    logic [2:0]  tdm_ch_m1 = 3'd0;
    logic [1:0]  sync_sel = 2'd0;
    logic        mono_en = 1'b0;
    logic        fill_prev = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = 32'd0;
    logic        s_ready, sdata, fsync, underrun;

    aud_serial_tx u_aud_serial_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fmt_sel(fmt_sel),
        .len_sel(len_sel), .narrow_slot(narrow_slot), .tdm_ch_m1(tdm_ch_m1),
        .sync_sel(sync_sel), .mono_en(mono_en), .fill_prev(fill_prev),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .sdata(sdata), .fsync(fsync), .underrun(underrun)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int div = 1;
    bit starve_en = 0;
    int cyc = 0;
    string sd_req = "R3";
    logic [31:0] lfsr = 32'h1234_5678;
    logic [31:0] q[$];

    // reference model state
    int m_pos = 0, m_slot = 0, m_len, m_sw, m_nch;
    logic [31:0] m_cur = 0, m_sent = 0, m_mask;
    logic m_prev = 0, m_raw, e_sd = 0, e_fs = 0, e_unf = 0, e_rdy;
    bit m_need, starving;

    function automatic int f_len(input logic [2:0] c);
        case (c)
            3'd0: return 32;  3'd1: return 24;  3'd2: return 20;  3'd3: return 18;
            3'd4, 3'd5: return 16;
            default: return 8;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_slot = 0; m_sent = 0; m_cur = 0; m_prev = 0;
            e_sd = 0; e_fs = 0; e_unf = 0;
        end else begin
            e_unf = 0;
            if (bit_en) begin
                m_len  = f_len(len_sel);
                m_sw   = (!fmt_sel[1] && narrow_slot && len_sel >= 3'd1 && len_sel <= 3'd3) ? 24 : 32;
                m_nch  = fmt_sel[1] ? (int'(tdm_ch_m1) + 1) : 2;
                m_mask = (m_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_len) - 32'd1);
                if (m_pos == 0) begin
                    m_need = !(mono_en && (m_slot % 2 == 1));
                    if (!m_need) m_cur = m_sent;
                    else if (s_valid) begin
                        m_cur = s_data & m_mask;
                        void'(q.pop_front());
                    end else begin
                        m_cur = fill_prev ? m_sent : 32'd0;
                        e_unf = 1;
                    end
                    m_sent = m_cur;
                end
                m_raw = (m_pos < m_len) ? m_cur[m_len-1-m_pos] : 1'b0;
                case (fmt_sel)
                    2'd0: e_fs = (m_slot == 1);
                    2'd1: e_fs = (m_slot == 0);
                    default: case (sync_sel)
                        2'd1: e_fs = (m_slot * 32 + m_pos) < (m_nch * 16);
                        2'd2: e_fs = (m_slot == 0) && (m_pos == 0);
                        default: e_fs = (m_slot == 0);
                    endcase
                endcase
                e_sd = (fmt_sel == 2'd0 || fmt_sel == 2'd2) ? m_prev : m_raw;
                m_prev = m_raw;
                m_pos++;
                if (m_pos == m_sw) begin
                    m_pos = 0;
                    m_slot = (m_slot + 1 == m_nch) ? 0 : m_slot + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sd_req, sdata, e_sd);
            check("R7 R8 fsync", fsync, e_fs);
            check("R11 underrun", underrun, e_unf);
        end
        cyc++;
        while (q.size() < 4) begin
            q.push_back(lfsr);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        end
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        bit_en = rst_n && ((cyc % div) == 0);
        starving = starve_en && ((cyc % 400) >= 200) && ((cyc % 400) < 300);
        s_valid = rst_n && !starving;
        s_data = s_valid ? q[0] : ~lfsr;
        e_rdy = bit_en && (m_pos == 0) && !(mono_en && (m_slot % 2 == 1));
        #1;
        if (rst_n && !done) check("R9 R10 ready", s_ready, e_rdy);
    end

    task automatic phase(input string tag, input logic [1:0] f, input logic [2:0] l,
                         input logic nar, input logic [2:0] ch, input logic [1:0] sy,
                         input logic mo, input logic fp, input int d, input bit st);
        @(posedge clk); #2;
        rst_n = 0;
        fmt_sel = f; len_sel = l; narrow_slot = nar; tdm_ch_m1 = ch; sync_sel = sy;
        mono_en = mo; fill_prev = fp; div = d; starve_en = st; sd_req = tag;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 sdata", sdata, 1'b0);
        check("R1 fsync", fsync, 1'b0);
        check("R1 underrun", underrun, 1'b0);
        check("R1 ready", s_ready, 1'b0);
        rst_n = 1;
        repeat (1500) @(posedge clk);
    endtask

    initial begin
        phase("R3 R5 R7 R2 i2s16",      2'd0, 3'd4, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 2, 1);
        phase("R4 R5 R12 i2s24n",       2'd0, 3'd1, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 1, 1);
        phase("R3 R5 R2 lj32",          2'd1, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 3, 1);
        phase("R3 R4 lj20w",            2'd1, 3'd2, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 1, 1);
        phase("R6 R8 tdm8",             2'd2, 3'd0, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0, 1, 1);
        phase("R4 R6 R8 R12 tdm4half",  2'd2, 3'd1, 1'b1, 3'd3, 2'd1, 1'b0, 1'b1, 2, 1);
        phase("R3 R5 R8 tdmlj3bit",     2'd3, 3'd7, 1'b0, 3'd2, 2'd2, 1'b0, 1'b0, 1, 1);
        phase("R10 R4 i2smono18",       2'd0, 3'd3, 1'b1, 3'd0, 2'd0, 1'b1, 1'b0, 1, 1);
        phase("R10 R12 tdm5mono",       2'd2, 3'd5, 1'b0, 3'd4, 2'd3, 1'b1, 1'b1, 2, 1);
        phase("R6 R8 tdm1half",         2'd2, 3'd6, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0, 1, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule